// File: doc/BRIEF.md
# Round-Robin Multi-Core Multiplier

This block multiplies a stream of unsigned operand pairs at the full rate of a single fast clock. It contains several identical, slower multiplier cores. An operand pair arriving in slot s goes to core s mod N. That core has N fast cycles to form its product. A rotating output selector then collects the finished products in the order the pairs arrived. No single core ever has to finish a product within one fast cycle, yet the block as a whole accepts one pair and delivers one product per cycle.

One fast clock drives the whole block. The per-core "slow clock" is an enable: core k loads new operands only in the cycle in which a modulo-N phase counter reads k. The same counter drives the output selector. The operand and product ports are registered. A valid flag travels with each slot, so idle slots stay visible at the output. The core count must be at least 2 and must divide the fast rate given in MHz. Any other value stops elaboration. Each core is a radix-2^C shift-add multiplier that finishes in N-1 steps, with C = ceil(WIDTH/(N-1)).

Top module: `rr_mult_array`

## Requirements
- R1: The block accepts a pair in every cycle in which in_valid is high, with no stall, and produces one result per cycle for an uninterrupted input stream.
- R2: For a valid slot, out_prod equals the full unsigned product in_a × in_b, 2×WIDTH bits wide, with no truncation.
- R3: The result of a pair sampled at clock edge E appears on out_prod/out_valid after edge E+N+1 (N = CORES). Results leave in the same order the pairs arrived.
- R4: out_valid is high exactly for the slots whose in_valid was high. An idle slot produces out_valid low in the matching output cycle.
- R5: A synchronous reset clears the phase counter and every valid flag. out_valid is low after the reset edge, and no pair sampled before or during reset ever shows up at the output.
- R6: A pair's result is not disturbed by the pairs in the following N-1 slots (which go to other cores), nor by the pair that reuses the same core N slots later.
- R7: Operand extremes are exact: all-ones × all-ones gives 2^(2W) − 2^(W+1) + 1, any operand of zero gives zero, and 1 × x gives x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared by the whole block |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on in_a/in_b is valid this cycle |
| in_a | input | WIDTH | Unsigned multiplicand |
| in_b | input | WIDTH | Unsigned multiplier |
| out_valid | output | 1 | out_prod holds a result this cycle |
| out_prod | output | 2*WIDTH | Unsigned product |

## Verification
A phase counter that skips or repeats a value hands a pair to the wrong core or reads a core too early. That shows up at the output within N+1 cycles as a wrong product or a product in the wrong slot. A core whose valid flag leaks between turns shows as an output valid in a slot that was idle. A shift-add step count that falls short corrupts products whose high multiplier bits are set. The bench keeps a per-slot model of the expected output and compares every cycle. Any of these faults is therefore reported within one round of N+2 cycles after the first pair it affects.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    // Multiplier bits retired per shift-add step so that a core finishes
    // its product in (cores - 1) steps.
    function automatic int chunk_of(input int width, input int cores);
        return (width + cores - 2) / (cores - 1);
    endfunction

endpackage

// File: rtl/rrm_phase_gen.sv
module rrm_phase_gen #(
    parameter int CORES = 5
) (
    input  logic                                  clk,
    input  logic                                  rst,
    output logic [((CORES > 1) ? $clog2(CORES) : 1)-1:0] phase,
    output logic [CORES-1:0]                      cap_en
);
    localparam int PHW = (CORES > 1) ? $clog2(CORES) : 1;
    localparam logic [PHW-1:0] LAST = PHW'(CORES - 1);

    typedef struct packed {
        logic [PHW-1:0] ph;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == LAST) begin
            st_d.ph = '0;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;

    for (genvar k = 0; k < CORES; k++) begin : g_en
        assign cap_en[k] = (st_q.ph == PHW'(k));
    end

    // Phase rotation: every core gets exactly one turn per round (R6)
    p_phase_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST) |=> (phase == '0));
    p_phase_step_r6: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> (phase == $past(phase) + 1'b1));
    p_one_core_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot(cap_en));

endmodule

// File: rtl/rrm_core.sv
module rrm_core #(
    parameter int WIDTH = 16,
    parameter int CORES = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap,
    input  logic               in_vld,
    input  logic [WIDTH-1:0]   in_a,
    input  logic [WIDTH-1:0]   in_b,
    output logic               out_vld,
    output logic [2*WIDTH-1:0] out_prod
);
    localparam int STEPS = CORES - 1;
    localparam int CHUNK = rrm_pkg::chunk_of(WIDTH, CORES);
    localparam int MW    = CHUNK * STEPS;
    localparam int PW    = 2 * WIDTH;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] acc;
        logic [PW-1:0] mcand;
        logic [MW-1:0] mplier;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.vld    = in_vld;
            st_d.acc    = '0;
            st_d.mcand  = PW'(in_a);
            st_d.mplier = MW'(in_b);
        end else begin
            for (int j = 0; j < CHUNK; j++) begin
                if (st_q.mplier[j]) begin
                    st_d.acc = st_d.acc + (st_q.mcand << j);
                end
            end
            st_d.mcand  = st_q.mcand << CHUNK;
            st_d.mplier = st_q.mplier >> CHUNK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign out_prod = st_q.acc;

    // A core's slot flag only changes on its own turn (R6)
    p_hold_vld_r6: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(out_vld));
    // The slot flag is taken from the operand register on a turn (R4)
    p_load_vld_r4: assert property (@(posedge clk) disable iff (rst)
        cap |=> (out_vld == $past(in_vld)));
    // The product is cleared on a turn before accumulation restarts (R2)
    p_load_clear_r2: assert property (@(posedge clk) disable iff (rst)
        cap |=> (out_prod == '0));

endmodule

// File: rtl/rr_mult_array.sv
module rr_mult_array #(
    parameter int WIDTH         = 16,
    parameter int CORES         = 5,
    parameter int FAST_RATE_MHZ = 200
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   in_a,
    input  logic [WIDTH-1:0]   in_b,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] out_prod
);
    localparam int PW  = 2 * WIDTH;
    localparam int PHW = (CORES > 1) ? $clog2(CORES) : 1;

    if (CORES < 2 || (FAST_RATE_MHZ % CORES) != 0) begin : g_bad_cores
        $error("rr_mult_array: CORES must be >= 2 and divide FAST_RATE_MHZ");
    end

    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
    } in_t;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } out_t;

    typedef struct packed {
        in_t  inp;
        out_t outp;
    } st_t;

    st_t st_d, st_q;

    logic [PHW-1:0]   phase;
    logic [CORES-1:0] cap_en;
    logic [CORES-1:0] core_vld;
    logic [PW-1:0]    core_prod [CORES];
    logic             mux_vld;
    logic [PW-1:0]    mux_prod;

    rrm_phase_gen #(.CORES(CORES)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .cap_en (cap_en)
    );

    for (genvar k = 0; k < CORES; k++) begin : g_core
        rrm_core #(.WIDTH(WIDTH), .CORES(CORES)) u_core (
            .clk      (clk),
            .rst      (rst),
            .cap      (cap_en[k]),
            .in_vld   (st_q.inp.vld),
            .in_a     (st_q.inp.a),
            .in_b     (st_q.inp.b),
            .out_vld  (core_vld[k]),
            .out_prod (core_prod[k])
        );
    end

    // Output selector: the core whose turn it is has just finished its round
    always_comb begin
        mux_vld  = 1'b0;
        mux_prod = '0;
        for (int k = 0; k < CORES; k++) begin
            if (phase == PHW'(k)) begin
                mux_vld  = core_vld[k];
                mux_prod = core_prod[k];
            end
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.inp.vld   = in_valid;
        st_d.inp.a     = in_a;
        st_d.inp.b     = in_b;
        st_d.outp.vld  = mux_vld;
        st_d.outp.prod = mux_prod;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.outp.vld;
    assign out_prod  = st_q.outp.prod;

    // Output slot flag follows the selected core one cycle later (R4)
    p_out_follow_r4: assert property (@(posedge clk) disable iff (rst)
        mux_vld |=> out_valid);
    p_out_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !mux_vld |=> !out_valid);
    // Selected product is carried into the output register (R2)
    p_out_prod_r2: assert property (@(posedge clk) disable iff (rst)
        mux_vld |=> (out_prod == $past(mux_prod)));

endmodule

// File: tb/tb_rr_mult_array.sv
module tb_rr_mult_array;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int NC = 5;
    localparam int L  = NC + 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic [W-1:0]   in_a, in_b;
    logic           out_valid;
    logic [2*W-1:0] out_prod;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    bit             h_known [L];
    bit             h_vld   [L];
    logic [2*W-1:0] h_prod  [L];
    string          h_tag   [L];

    rr_mult_array #(.WIDTH(W), .CORES(NC), .FAST_RATE_MHZ(200)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] wa, wb;
        wa = {{W{1'b0}}, a};
        wb = {{W{1'b0}}, b};
        return wa * wb;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: out_valid actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_prod(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: out_prod actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One slot: check the slot that was driven L negedges ago, then drive
    task automatic tick(input bit r, input bit v, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string tag);
        @(negedge clk);
        if (h_known[L-1]) begin
            check_bit({h_tag[L-1], " R4"}, out_valid, h_vld[L-1]);
            if (h_vld[L-1]) check_prod(h_tag[L-1], out_prod, h_prod[L-1]);
        end
        for (int i = L-1; i > 0; i--) begin
            h_known[i] = h_known[i-1];
            h_vld[i]   = h_vld[i-1];
            h_prod[i]  = h_prod[i-1];
            h_tag[i]   = h_tag[i-1];
        end
        h_known[0] = 1'b1;
        h_vld[0]   = v && !r;
        h_prod[0]  = ref_mul(a, b);
        h_tag[0]   = tag;
        if (r) begin
            // R5: everything in flight is discarded by the reset edge
            for (int i = 0; i < L; i++) begin
                h_known[i] = 1'b1;
                h_vld[i]   = 1'b0;
                h_tag[i]   = "R5";
            end
        end
        rst      = r;
        in_valid = v;
        in_a     = a;
        in_b     = b;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ones;
        int unsigned  seed;
        ones = '1;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        for (int i = 0; i < L; i++) begin
            h_known[i] = 1'b0;
            h_vld[i]   = 1'b0;
            h_prod[i]  = '0;
            h_tag[i]   = "";
        end
        rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0;

        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, '0, '0, "R5");
        // Reset state: output invalid after the reset edges (R5)
        check_bit("R5 reset state", out_valid, 1'b0);

        // R7: operand extremes, back to back (R1 no stall)
        tick(1'b0, 1'b1, ones, ones, "R7 max*max");
        tick(1'b0, 1'b1, '0, ones, "R7 zero*max");
        tick(1'b0, 1'b1, ones, '0, "R7 max*zero");
        tick(1'b0, 1'b1, 16'd1, 16'hBEEF, "R7 one*x");
        tick(1'b0, 1'b1, 16'h8001, 16'd1, "R7 x*one");
        tick(1'b0, 1'b1, ones, 16'h8000, "R7 max*msb");
        for (int i = 0; i < L; i++) tick(1'b0, 1'b0, '0, '0, "R4 idle");

        // R1/R6: unbroken stream, every core reused many times
        for (int i = 0; i < 40; i++)
            tick(1'b0, 1'b1, W'($urandom), W'($urandom), "R1 R6 stream");
        // R4: alternating gaps
        for (int i = 0; i < 30; i++)
            tick(1'b0, (i % 3) != 1, W'($urandom), W'($urandom), "R4 gaps");

        // R3: long random stream with gaps, order and latency by slot model
        for (int i = 0; i < 2500; i++)
            tick(1'b0, ($urandom % 4) != 0, W'($urandom), W'($urandom), "R3 R2 random");

        // R5: reset in mid-stream, in-flight results must vanish
        for (int i = 0; i < 3; i++)
            tick(1'b0, 1'b1, W'($urandom), W'($urandom), "R3 pre-reset");
        tick(1'b1, 1'b1, ones, ones, "R5");
        tick(1'b1, 1'b1, ones, ones, "R5");
        check_bit("R5 mid-stream reset", out_valid, 1'b0);
        for (int i = 0; i < 200; i++)
            tick(1'b0, ($urandom % 2) != 0, W'($urandom), W'($urandom), "R5 R3 after reset");
        for (int i = 0; i < L + 1; i++) tick(1'b0, 1'b0, '0, '0, "R4 drain");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule